// File: doc/BRIEF.md
# Interrupt Status Byte and Clock-Chip Serial Port

This block collects the interrupt and line state of a small peripheral cluster into one eight-bit status byte. It also runs the software-driven serial link to an external real-time clock chip. Two interrupt sources are latched as sticky flags. One is a once-per-second pulse from the clock chip, which arrives asynchronously. The other is a single-cycle timeout strobe from the system timer. Bit 7 of the byte summarises the two flags.

The serial link has four wires: the one-second interrupt input, a serial clock output, a chip-enable output and one bidirectional data wire. Software writes a control register to set the clock, enable, data-out and output-enable levels, and toggles them itself to shift data. While the output-enable bit is clear, the data wire is released and its level can be read back through the status byte.

The one-second input passes through a synchroniser into a two-state edge tracker. The states are `SEC_LOW` (the last synchronised level was low) and `SEC_HIGH` (the last synchronised level was high). The transition `SEC_LOW` to `SEC_HIGH` is taken when the synchronised level is high, and it emits a one-cycle set pulse. The transition `SEC_HIGH` to `SEC_LOW` is taken when the synchronised level returns low, and it emits nothing. Both states hold otherwise. The tracker resets to `SEC_LOW`.

Top module: `stat_rtc_port`

## Requirements
- R1: After reset the flags (status bits 0, 1 and 7) read 0. The control register reads 0, so the serial clock, chip enable and sound enable outputs are low, status bits 5 and 6 are 0, and the data wire is released.
- R2: A rising edge on the one-second input sets status bit 0 at the third rising clock edge after the input rises. A level that stays high sets it only once.
- R3: A timer strobe high at a rising clock edge sets status bit 1 at that edge.
- R4: A write to register index 0 clears status bit 0 where data bit 0 is 1, and clears status bit 1 where data bit 1 is 1. Bits written as 0, and writes to any other index, leave the flags unchanged.
- R5: When a set and a clear of the same flag meet at one edge, the flag ends up set.
- R6: Status bit 7 equals the OR of status bits 0 and 1 at all times.
- R7: Status bit 2 follows the peripheral interrupt pin, and status bit 4 follows register address bit 3, both with no clock delay.
- R8: A write to register index 5 loads the control register at that edge. Data bit 0 drives the serial clock, bit 1 the chip enable, bit 2 the data-out level, bit 3 the output enable, and bit 4 the sound-counter enable. Status bit 5 shows bit 4, and status bit 6 shows bit 3. Writes to other indices leave the control register unchanged.
- R9: While the output enable is 1, the data wire carries the data-out bit. While it is 0, the wire is released so another driver can set it. In both cases status bit 3 shows the level on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | ADDR_W | Register index on the bus |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| status_o | output | 8 | Status byte |
| sec_irq_i | input | 1 | One-second pulse from the clock chip (asynchronous) |
| tmr_tick_i | input | 1 | Timer timeout strobe (synchronous) |
| pbus_irq_i | input | 1 | Peripheral-bus interrupt pin |
| rtc_sclk_o | output | 1 | Serial clock to the clock chip |
| rtc_ce_o | output | 1 | Chip enable to the clock chip |
| rtc_dio | inout | 1 | Bidirectional serial data wire |
| snd_cnt_en_o | output | 1 | Sound-counter enable control |

## Verification
Each flag can be set by its source and cleared by software in the same cycle. The bench provokes this in three ways. A timer strobe is driven alongside a clearing write to index 0. A clearing write is placed in the exact cycle when the edge tracker's set pulse for a one-second edge is active. A random stream mixes strobes and clearing writes freely. The status byte is then compared one cycle later against a model in which the set always wins, with bit 7 recomputed from the expected flags.

// File: rtl/stat_rtc_pkg.sv
package stat_rtc_pkg;
    localparam int STAT_W    = 8;
    localparam int CTRL_W    = 5;
    localparam int NUM_FLAGS = 2;
    localparam int FLG_SEC   = 0;
    localparam int FLG_TMR   = 1;

    typedef enum logic {
        SEC_LOW  = 1'b0,
        SEC_HIGH = 1'b1
    } sec_state_t;

    // Field order is the write-data bit order (sclk at bit 0).
    typedef struct packed {
        logic snd_en;
        logic oe;
        logic dout;
        logic ce;
        logic sclk;
    } rtc_ctrl_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/sec_edge_fsm.sv
module sec_edge_fsm
    import stat_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic set_pulse
);
    sec_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEC_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        set_pulse = 1'b0;
        unique case (state)
            SEC_LOW: begin
                if (lvl) begin
                    state_nx  = SEC_HIGH;
                    set_pulse = 1'b1;
                end
            end
            SEC_HIGH: begin
                if (!lvl) state_nx = SEC_LOW;
            end
        endcase
    end
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            // set has priority so a coincident event is never lost
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      flags[i] <= 1'b0;
                else if (set[i]) flags[i] <= 1'b1;
                else if (clr[i]) flags[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import stat_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  rtc_ctrl_t din,
    output rtc_ctrl_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/stat_rtc_port.sv
module stat_rtc_port
    import stat_rtc_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int IDX_STATUS  = 0,
    parameter int IDX_RTC     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        status_o,
    input  logic              sec_irq_i,
    input  logic              tmr_tick_i,
    input  logic              pbus_irq_i,
    output logic              rtc_sclk_o,
    output logic              rtc_ce_o,
    inout  wire               rtc_dio,
    output logic              snd_cnt_en_o
);
    localparam int ADDR_HI = 3;

    logic                 sec_lvl;
    logic                 sec_set;
    logic                 wr_stat;
    logic                 wr_rtc;
    logic [NUM_FLAGS-1:0] f_set;
    logic [NUM_FLAGS-1:0] f_clr;
    logic [NUM_FLAGS-1:0] flags;
    rtc_ctrl_t            ctrl;
    logic                 unused_bits;

    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(IDX_STATUS));
    assign wr_rtc  = reg_wr && (reg_addr == ADDR_W'(IDX_RTC));

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sec_irq_i),
        .q     (sec_lvl)
    );

    sec_edge_fsm u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (sec_lvl),
        .set_pulse (sec_set)
    );

    always_comb begin
        f_set          = '0;
        f_set[FLG_SEC] = sec_set;
        f_set[FLG_TMR] = tmr_tick_i;
        f_clr          = wr_stat ? reg_wdata[NUM_FLAGS-1:0] : '0;
    end

    irq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (f_set),
        .clr   (f_clr),
        .flags (flags)
    );

    rtc_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_rtc),
        .din   (rtc_ctrl_t'(reg_wdata[CTRL_W-1:0])),
        .q     (ctrl)
    );

    assign rtc_dio      = ctrl.oe ? ctrl.dout : 1'bz;
    assign rtc_sclk_o   = ctrl.sclk;
    assign rtc_ce_o     = ctrl.ce;
    assign snd_cnt_en_o = ctrl.snd_en;

    always_comb begin
        status_o    = '0;
        status_o[0] = flags[FLG_SEC];
        status_o[1] = flags[FLG_TMR];
        status_o[2] = pbus_irq_i;
        status_o[3] = rtc_dio;
        status_o[4] = reg_addr[ADDR_HI];
        status_o[5] = ctrl.snd_en;
        status_o[6] = ctrl.oe;
        status_o[7] = |flags;
    end

    assign unused_bits = ^reg_wdata[7:CTRL_W];
endmodule

// File: rtl/stat_rtc_chk.sv
module stat_rtc_chk #(
    parameter int ADDR_W     = 4,
    parameter int IDX_STATUS = 0,
    parameter int IDX_RTC    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        status_o,
    input logic              tmr_tick_i,
    input logic              rtc_sclk_o,
    input logic              rtc_ce_o,
    input logic              snd_cnt_en_o
);
    logic clr_stat;
    logic wr_ctl;
    assign clr_stat = reg_wr && (reg_addr == ADDR_W'(IDX_STATUS));
    assign wr_ctl   = reg_wr && (reg_addr == ADDR_W'(IDX_RTC));

    p_tick_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tick_i |=> status_o[1]);

    p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stat && reg_wdata[1] && !tmr_tick_i) |=> !status_o[1]);

    p_flag_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !(clr_stat && reg_wdata[0])) |=> status_o[0]);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick_i && clr_stat && reg_wdata[1]) |=> status_o[1]);

    p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7] == (status_o[0] || status_o[1]));

    p_ctrl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (rtc_ce_o == $past(reg_wdata[1])) &&
                   (snd_cnt_en_o == $past(reg_wdata[4])));

    p_ctrl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> $stable({rtc_sclk_o, rtc_ce_o, snd_cnt_en_o, status_o[6]}));
endmodule

bind stat_rtc_port stat_rtc_chk #(
    .ADDR_W(ADDR_W), .IDX_STATUS(IDX_STATUS), .IDX_RTC(IDX_RTC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .status_o     (status_o),
    .tmr_tick_i   (tmr_tick_i),
    .rtc_sclk_o   (rtc_sclk_o),
    .rtc_ce_o     (rtc_ce_o),
    .snd_cnt_en_o (snd_cnt_en_o)
);

// File: tb/sim_stat_rtc_port.sv
`timescale 1ns/1ps
module sim_stat_rtc_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       sec_irq = 1'b0;
    logic       tmr_tick = 1'b0;
    logic       pbus_irq = 1'b0;
    logic       tb_drv = 1'b1;
    logic       tb_val = 1'b0;
    logic [7:0] status;
    logic       sclk, ce, snd_en;
    wire        rtc_dio;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic       e_f0, e_f1;
    logic [4:0] e_ctl;

    assign rtc_dio = tb_drv ? tb_val : 1'bz;

    always #2.5 clk = ~clk;

    stat_rtc_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .status_o(status), .sec_irq_i(sec_irq),
        .tmr_tick_i(tmr_tick), .pbus_irq_i(pbus_irq), .rtc_sclk_o(sclk),
        .rtc_ce_o(ce), .rtc_dio(rtc_dio), .snd_cnt_en_o(snd_en)
    );

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected {status, sclk, ce, snd_en, dio}
    function automatic logic [11:0] exp_vec(logic [3:0] a, logic p, logic v);
        logic pin;
        logic [7:0] s;
        pin = e_ctl[3] ? e_ctl[2] : v;
        s = {e_f0 | e_f1, e_ctl[3], e_ctl[4], a[3], pin, p, e_f1, e_f0};
        return {s, e_ctl[0], e_ctl[1], e_ctl[4], pin};
    endfunction

    task automatic model_reset();
        e_f0 = 0; e_f1 = 0; e_ctl = '0;
    endtask

    task automatic step(logic [3:0] a, logic w, logic [7:0] d, logic t,
                        logic p, logic v, string req);
        logic clr;
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; tmr_tick = t;
        pbus_irq = p; tb_val = v; tb_drv = !e_ctl[3];
        #1;
        check(req, {status, sclk, ce, snd_en, rtc_dio}, exp_vec(a, p, v));
        clr = w && (a == 4'd0);
        e_f1 = t | (e_f1 & ~(clr & d[1]));
        e_f0 = e_f0 & ~(clr & d[0]);
        if (w && a == 4'd5) e_ctl = d[4:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; reg_wr = 0; tmr_tick = 0; sec_irq = 0; tb_drv = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic idle_to(logic w, logic [7:0] d);
        @(negedge clk);
        reg_addr = 4'd0; reg_wr = w; reg_wdata = d; tmr_tick = 0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        do_reset();
        step(4'd0, 0, 8'h00, 0, 0, 0, "R1 reset state");

        // one-second edge path: pin rises, flag appears at third edge (R2)
        @(negedge clk); sec_irq = 1; reg_wr = 0;
        idle_to(0, 8'h00);
        check("R2 not yet after edge 1", {11'd0, status[0]}, 12'd0);
        idle_to(0, 8'h00);
        check("R2 not yet after edge 2", {11'd0, status[0]}, 12'd0);
        idle_to(1, 8'h01);
        check("R2 set after edge 3", {11'd0, status[0]}, 12'd1);
        check("R6 summary with sec flag", {11'd0, status[7]}, 12'd1);
        idle_to(0, 8'h00);
        check("R4 sec flag cleared", {11'd0, status[0]}, 12'd0);
        repeat (4) idle_to(0, 8'h00);
        check("R2 held level no retrigger", {11'd0, status[0]}, 12'd0);
        @(negedge clk); sec_irq = 0;
        repeat (3) idle_to(0, 8'h00);
        @(negedge clk); sec_irq = 1;
        idle_to(0, 8'h00);
        idle_to(1, 8'h01);          // clear meets the set pulse
        idle_to(0, 8'h00);
        check("R5 sec set beats clear", {11'd0, status[0]}, 12'd1);
        check("R6 summary follows", {11'd0, status[7]}, 12'd1);
        idle_to(1, 8'h01);
        @(negedge clk); sec_irq = 0; reg_wr = 0;

        do_reset();
        // directed timer, clear and control cases
        step(4'd0, 0, 8'h00, 1, 1, 1, "R3 R7 tick with pins");
        step(4'd0, 1, 8'h00, 0, 0, 0, "R3 flag set");
        step(4'd8, 1, 8'hFF, 0, 1, 0, "R4 zero write kept flag R7 addr bit");
        step(4'd0, 1, 8'h02, 1, 0, 1, "R4 other index kept flag");
        step(4'd0, 0, 8'h00, 0, 0, 0, "R5 tick beats clear");
        step(4'd0, 1, 8'h02, 0, 0, 0, "R5 flag still set");
        step(4'd5, 1, 8'h0C, 0, 0, 1, "R4 flag cleared");
        step(4'd4, 1, 8'hFF, 0, 0, 0, "R8 R9 drive high");
        step(4'd5, 1, 8'h08, 0, 0, 0, "R8 other index kept ctrl");
        step(4'd5, 1, 8'h13, 0, 0, 0, "R9 drive low");
        step(4'd0, 0, 8'h00, 0, 0, 1, "R8 R9 released reads pin");
        step(4'd5, 1, 8'h00, 0, 0, 0, "R9 released low");
        step(4'd0, 0, 8'h00, 0, 0, 0, "R8 ctrl cleared");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            logic [7:0] d;
            d = 8'($urandom);
            case ($urandom % 4)
                0: a = 4'd0;
                1: a = 4'd5;
                2: a = 4'd8;
                default: a = 4'($urandom);
            endcase
            step(a, 1'($urandom % 2), d, ($urandom % 4) == 0,
                 1'($urandom), 1'($urandom), "R3 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule